// File: doc/BRIEF.md
# TDM Slot Sync Generator

This block divides a shared serial bit clock into a repeating frame of eight time slots, each eight bits long, and gives every channel a one-bit-wide sync strobe at the first bit of its own slot. Eight single-channel PCM ports that all drive one common serial line (released outside their slot, so the line combines as wired-OR) use these strobes to know when to send their byte, most significant bit first. With a 512 kHz bit clock the 64-bit frame repeats at 8 kHz.

Each rising edge of `clk` is one bit period. A small counter marks the bit position within a slot, and a one-hot ring moves the active channel from the first to the last in turn. A frame-start marker is raised together with the first channel's strobe. The channel count and the slot length are parameters.

Top module: `tdm_slot_sync`

## Requirements
- R1: While `rst_n` is low, every bit of `sync` and `frame_start` is 0.
- R2: On the first rising clock edge after `rst_n` goes high, `sync` becomes 1 on bit 0 only (channel 1) and `frame_start` becomes 1; this also holds after a reset applied in the middle of a frame.
- R3: Each channel strobe is high for exactly one clock cycle per frame.
- R4: At most one bit of `sync` is high in any cycle.
- R5: Consecutive strobes are exactly SLOT_BITS (default 8) cycles apart, with `sync` all-zero for the SLOT_BITS-1 cycles between them.
- R6: `frame_start` is high for one cycle every CHANNELS*SLOT_BITS (default 64) cycles, in the same cycle as `sync[0]` and in no other cycle.
- R7: Strobes go in order from `sync[0]` to `sync[CHANNELS-1]` and then wrap back to `sync[0]`; with defaults, bit index b after release (b counted from 0) has `sync` equal to 1 << ((b/8) mod 8) when b mod 8 is 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one edge per bit period |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | output | CHANNELS | One-hot per-channel slot strobes, bit 0 is channel 1 |
| frame_start | output | 1 | High in the first bit of each frame |

## Verification
On every cycle the assertions check that no two strobes overlap, that a strobe never lasts two cycles, that the gap between strobes is one slot, that the next strobe belongs to the next channel, that frames repeat at the full frame length, and that the first cycle after reset carries channel 1 with the frame marker. The quiet outputs during reset, the exact bit positions of each strobe within long runs, and the restart to channel 1 after a reset in mid-frame are shown only by the bench's scenarios.

// File: rtl/tdm_slot_sync.sv
module tdm_slot_sync #(
  parameter int CHANNELS  = 8,
  parameter int SLOT_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [CHANNELS-1:0] sync,
  output logic                frame_start
);
  localparam int BW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_BITS - 1);
  localparam logic [CHANNELS-1:0] RING_INIT = CHANNELS'(1) << (CHANNELS - 1);

  logic [BW-1:0]       bit_pos;
  logic [CHANNELS-1:0] ring;
  logic                slot_end;
  logic                slot_head;

  assign slot_end  = (bit_pos == LAST_BIT);
  assign slot_head = (bit_pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos <= LAST_BIT;
      ring    <= RING_INIT;
    end else begin
      bit_pos <= slot_end ? '0 : bit_pos + 1'b1;
      if (slot_end) ring <= {ring[CHANNELS-2:0], ring[CHANNELS-1]};
    end
  end

  assign sync        = slot_head ? ring : '0;
  assign frame_start = slot_head & ring[0];
endmodule

// File: rtl/tdm_slot_sync_chk.sv
module tdm_slot_sync_chk #(
  parameter int CHANNELS  = 8,
  parameter int SLOT_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CHANNELS-1:0] sync,
  input logic                frame_start
);
  localparam int FRAME = CHANNELS * SLOT_BITS;
  localparam int GW = $clog2(FRAME + 1);

  logic [GW-1:0]       gap, fgap;
  logic                seen, fseen;
  logic [CHANNELS-1:0] last;
  logic [1:0]          age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; fgap <= '0; seen <= 1'b0; fseen <= 1'b0; last <= '0; age <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (sync != '0) begin
        gap <= '0; seen <= 1'b1; last <= sync;
      end else if (gap != '1) gap <= gap + 1'b1;
      if (frame_start) begin
        fgap <= '0; fseen <= 1'b1;
      end else if (fgap != '1) fgap <= fgap + 1'b1;
    end
  end

  assert_first_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd1) |-> (sync == CHANNELS'(1) && frame_start));
  assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync != '0) |=> (sync == '0));
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync));
  assert_slot_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync != '0 && seen) |-> (gap == GW'(SLOT_BITS - 1)));
  assert_frame_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && fseen) |-> (fgap == GW'(FRAME - 1)));
  assert_marker_with_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> sync[0]);
  assert_channel_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync != '0 && seen) |-> (sync == {last[CHANNELS-2:0], last[CHANNELS-1]}));
endmodule

bind tdm_slot_sync tdm_slot_sync_chk #(.CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .frame_start(frame_start));

// File: tb/tb_tdm_slot_sync.sv
module tb_tdm_slot_sync;
  localparam int CH = 8;
  localparam int SB = 8;
  localparam int FRAME = CH * SB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CH-1:0] sync;
  logic frame_start;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  tdm_slot_sync #(.CHANNELS(CH), .SLOT_BITS(SB)) dut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .frame_start(frame_start));

  always #10 clk = ~clk;

  // {cycle after release (1 = first edge), expected sync, expected frame_start}
  localparam logic [16:0] VEC [12] = '{
    {8'd1,   8'h01, 1'b1}, {8'd2,   8'h00, 1'b0}, {8'd8,   8'h00, 1'b0},
    {8'd9,   8'h02, 1'b0}, {8'd10,  8'h00, 1'b0}, {8'd17,  8'h04, 1'b0},
    {8'd33,  8'h10, 1'b0}, {8'd57,  8'h80, 1'b0}, {8'd64,  8'h00, 1'b0},
    {8'd65,  8'h01, 1'b1}, {8'd73,  8'h02, 1'b0}, {8'd129, 8'h01, 1'b1}};

  function automatic logic [CH-1:0] exp_sync(int b);
    return (b % SB == 0) ? (CH'(1) << ((b / SB) % CH)) : '0;
  endfunction

  task automatic chk(string req, logic [CH:0] got, logic [CH:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got sync/frame_start %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int cyc;
    // R1: outputs quiet through several edges of reset
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R1", {sync, frame_start}, '0);
    end
    rst_n = 1'b1;
    cyc = 0;
    for (int v = 0; v < 12; v++) begin
      while (cyc < int'(VEC[v][16:9])) begin
        step();
        cyc++;
      end
      chk(v == 0 ? "R2" : "R7", {sync, frame_start}, {VEC[v][8:1], VEC[v][0]});
    end
    // full scan of three frames: R3 R4 R5 R6 R7
    for (int b = cyc; b < cyc + 3 * FRAME; b++) begin
      logic [CH-1:0] e;
      step();
      e = exp_sync(b);
      chk((b % SB == 0) ? "R5" : "R4", {sync, frame_start}, {e, e[0]});
    end
    // mid-frame reset: R1 then R2
    repeat (21) step();
    rst_n = 1'b0;
    #1 chk("R1", {sync, frame_start}, '0);
    step();
    chk("R1", {sync, frame_start}, '0);
    rst_n = 1'b1;
    step();
    chk("R2", {sync, frame_start}, {CH'(1), 1'b1});
    step();
    chk("R3", {sync, frame_start}, '0);
    repeat (SB - 1) step();
    chk("R5", {sync, frame_start}, {CH'(2), 1'b0});
    repeat (FRAME - SB) step();
    chk("R6", {sync, frame_start}, {CH'(1), 1'b1});
    finish_run();
  end

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule